// File: doc/BRIEF.md
# Aperture Address Remapper with Shadow Offset Registers

This block rewrites a 32-bit CPU address. The address space is split into sixteen windows of 256 MB each. The top four address bits pick a window. Each window has a 4-bit replacement value, and that value becomes the new top nibble of the outgoing address. The lower 28 bits pass through unchanged. The output is combinational from the input address and the live offset table.

Software sets the replacement values through a simple 32-bit register port. Writes land only in a pending (shadow) table. The live table used for translation is reloaded from the pending table all at once, and only when software writes a one to a commit bit. A whole new map can therefore be staged across several writes and switched in a single cycle, so the decoder never sees a half-written map. The commit bit clears itself once the reload is done.

Top module: `aperture_remap`

## Requirements
- R1: After reset, both the pending and live tables hold the default map. The word at 0x1028 reads 0x0000_0000 and the word at 0x102C reads 0x0ED0_3210. The update word at 0x1034 reads 0.
- R2: `out_addr` equals `{live[in_addr[31:28]], in_addr[27:0]}`, where window k's value is field k of the map.
- R3: A write to 0x1028 sets windows 0..7, and a write to 0x102C sets windows 8..15. Window k uses bits [4*(k%8)+3 : 4*(k%8)] of its word. Such a write changes the value read back at that address but not `out_addr`.
- R4: Writing a value with bit 0 = 1 to 0x1034 at clock edge E makes bit 0 read 1 after E. At edge E+1 the live table is loaded from the pending table and bit 0 returns to 0.
- R5: A write to 0x1034 with bit 0 = 0 does not load the live table. Bits 31:1 of 0x1034 always read 0.
- R6: Reads of 0x1028 and 0x102C return the pending values, even when they differ from the live ones.
- R7: Reads of any other register address return 0, and writes to them change no register.
- R8: A single commit moves both words of the pending table to the live table on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| in_addr | input | 32 | CPU address to translate |
| out_addr | output | 32 | Translated address |

## Verification
A table of addresses, one per window and chosen with varied low bits, is checked against the default map. This separates a correct nibble swap from a wrong window index and from corrupted pass-through bits. Staged writes are then checked twice: before the commit, `out_addr` must still show the old map while readback shows the new one, and after the commit both words must appear at once. This separates shadowing from write-through and a single-word commit from an atomic one. Commit writes with bit 0 clear, along with writes to neighbouring unmapped addresses, show whether the decode ignores them.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;
    localparam int ADDR_W     = 32;
    localparam int SEL_W      = 4;
    localparam int N_AP       = 1 << SEL_W;
    localparam int DATA_W     = 32;
    localparam int REG_AW     = 16;
    localparam int PER_WORD   = DATA_W / SEL_W;
    localparam int N_WORDS    = N_AP / PER_WORD;
    localparam int WORD_BYTES = DATA_W / 8;

    typedef logic [N_AP-1:0][SEL_W-1:0] ap_map_t;

    typedef struct packed {
        ap_map_t shadow;
        ap_map_t active;
        logic    commit;
    } map_state_t;
endpackage

// File: rtl/aperture_regs.sv
module aperture_regs
    import aperture_remap_pkg::*;
#(
    parameter logic [REG_AW-1:0]    MAP_BASE  = 16'h1028,
    parameter logic [REG_AW-1:0]    UPD_ADDR  = 16'h1034,
    parameter logic [N_AP*SEL_W-1:0] RESET_MAP = 64'h0ED0_3210_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output ap_map_t           live_map
);
    map_state_t st_d, st_q;
    localparam map_state_t RST_ST = '{shadow: RESET_MAP, active: RESET_MAP, commit: 1'b0};

    always_comb begin
        st_d = st_q;
        if (st_q.commit) begin
            st_d.active = st_q.shadow;
            st_d.commit = 1'b0;
        end
        if (reg_we) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (reg_addr == MAP_BASE + REG_AW'(w * WORD_BYTES)) begin
                    for (int f = 0; f < PER_WORD; f++) begin
                        st_d.shadow[w*PER_WORD + f] = reg_wdata[f*SEL_W +: SEL_W];
                    end
                end
            end
            if (reg_addr == UPD_ADDR && reg_wdata[0]) begin
                st_d.commit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < N_WORDS; w++) begin
            if (reg_addr == MAP_BASE + REG_AW'(w * WORD_BYTES)) begin
                for (int f = 0; f < PER_WORD; f++) begin
                    reg_rdata[f*SEL_W +: SEL_W] = st_q.shadow[w*PER_WORD + f];
                end
            end
        end
        if (reg_addr == UPD_ADDR) reg_rdata = {{(DATA_W-1){1'b0}}, st_q.commit};
    end

    assign live_map = st_q.active;

    // R3: without a pending commit the live table holds its value
    a_r3_live_held: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.commit |=> $stable(st_q.active));
    // R4, R8: a pending commit loads the whole pending table on the next edge
    a_r4_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.commit |=> st_q.active == $past(st_q.shadow));
    // R4: the commit bit lasts one cycle unless rewritten
    a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.commit && !reg_we) |=> !st_q.commit);
    // R7: writes outside the register map leave the pending table unchanged
    a_r7_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr < MAP_BASE || reg_addr >= MAP_BASE + REG_AW'(N_WORDS*WORD_BYTES)))
        |=> $stable(st_q.shadow));
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
    import aperture_remap_pkg::*;
(
    input  logic [ADDR_W-1:0] in_addr,
    input  ap_map_t           live_map,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int LOW_W = ADDR_W - SEL_W;

    logic [N_AP-1:0]  win_hit;
    logic [SEL_W-1:0] new_top;

    for (genvar k = 0; k < N_AP; k++) begin : g_win
        assign win_hit[k] = (in_addr[ADDR_W-1 -: SEL_W] == SEL_W'(k));
    end

    always_comb begin
        new_top = '0;
        for (int k = 0; k < N_AP; k++) begin
            if (win_hit[k]) new_top = new_top | live_map[k];
        end
        out_addr = {new_top, in_addr[LOW_W-1:0]};
    end

    // R2: exactly one window matches any address
    always_comb a_r2_one_window: assert ($onehot0(win_hit) && win_hit != '0);
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
    import aperture_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] in_addr,
    output logic [ADDR_W-1:0] out_addr
);
    ap_map_t live_map;

    aperture_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .live_map  (live_map)
    );

    aperture_xlate u_xlate (
        .in_addr  (in_addr),
        .live_map (live_map),
        .out_addr (out_addr)
    );

    // R2: the low 28 bits pass through the register and mux stages untouched
    a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        out_addr[ADDR_W-SEL_W-1:0] == in_addr[ADDR_W-SEL_W-1:0]);
endmodule

// File: tb/aperture_remap_test.sv
module aperture_remap_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [31:0] in_addr = '0;
    logic [31:0] out_addr;

    int n_checks = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    aperture_remap uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .in_addr(in_addr), .out_addr(out_addr)
    );

    localparam int NV = 10;
    localparam logic [31:0] VIN  [NV] = '{32'h9ABC_DEF0, 32'hD000_0004, 32'hE123_4567, 32'hA000_0000,
                                          32'hBFFF_FFFF, 32'h8FFF_FFFF, 32'hF000_0001, 32'h5555_5555,
                                          32'h0000_0000, 32'hC765_4321};
    localparam logic [31:0] VEXP [NV] = '{32'h1ABC_DEF0, 32'hD000_0004, 32'hE123_4567, 32'h2000_0000,
                                          32'h3FFF_FFFF, 32'h0FFF_FFFF, 32'h0000_0001, 32'h0555_5555,
                                          32'h0000_0000, 32'h0765_4321};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic xl(input logic [31:0] a, output logic [31:0] o);
        in_addr = a;
        #1 o = out_addr;
    endtask

    initial begin
        #(PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(16'h1028, v); check("R1 word0 reset", v, 32'h0000_0000);
        rd(16'h102C, v); check("R1 word1 reset", v, 32'h0ED0_3210);
        rd(16'h1034, v); check("R1 update reset", v, 32'h0);

        // R2 default map table
        for (int i = 0; i < NV; i++) begin
            xl(VIN[i], v); check("R2 default map", v, VEXP[i]);
        end

        // R3 staged writes do not reach translation
        wr(16'h1028, 32'hFEDC_BA98);
        wr(16'h102C, 32'h1111_1111);
        rd(16'h1028, v); check("R3 word0 readback", v, 32'hFEDC_BA98);
        rd(16'h102C, v); check("R6 word1 readback pending", v, 32'h1111_1111);
        xl(32'h1234_5678, v); check("R3 no effect before commit", v, 32'h0234_5678);
        xl(32'hD000_0010, v); check("R6 live differs from pending", v, 32'hD000_0010);

        // R4 commit timing
        wr(16'h1034, 32'h0000_0001);
        rd(16'h1034, v); check("R4 update bit set", v, 32'h1);
        xl(32'h1234_5678, v); check("R4 not yet loaded", v, 32'h0234_5678);
        @(negedge clk);
        rd(16'h1034, v); check("R4 update self clear", v, 32'h0);
        xl(32'h1234_5678, v); check("R4 loaded", v, 32'h9234_5678);
        xl(32'h7000_0000, v); check("R8 word0 window7", v, 32'hF000_0000);
        xl(32'hDABC_0000, v); check("R8 word1 window13", v, 32'h1ABC_0000);

        // R5 write with bit0 clear does not commit
        wr(16'h1028, 32'h0000_0000);
        wr(16'h1034, 32'hFFFF_FFFE);
        repeat (3) @(negedge clk);
        rd(16'h1034, v); check("R5 reserved bits read 0", v, 32'h0);
        xl(32'h1234_5678, v); check("R5 no commit on bit0=0", v, 32'h9234_5678);

        // R7 unmapped addresses
        wr(16'h1030, 32'hAAAA_AAAA);
        wr(16'h1024, 32'h5555_5555);
        rd(16'h1030, v); check("R7 unmapped read 1030", v, 32'h0);
        rd(16'h1024, v); check("R7 unmapped read 1024", v, 32'h0);
        rd(16'h1028, v); check("R7 word0 untouched", v, 32'h0);
        rd(16'h102C, v); check("R7 word1 untouched", v, 32'h1111_1111);

        // R8 final commit restores word0 and keeps word1
        wr(16'h1034, 32'h1);
        @(negedge clk);
        xl(32'h7123_0000, v); check("R8 word0 zeroed", v, 32'h0123_0000);
        xl(32'hF123_0000, v); check("R8 word1 held", v, 32'h1123_0000);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule